// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block generates the internal word address for one port of a synchronous memory array. On every rising clock edge it chooses one of four actions for the next address. It can take an address from outside, step the current address up by one, return to a saved burst start, or keep the current address. The memory array samples the chosen address in the following cycle, and the address output is registered.

The controls are three active-low inputs: an address strobe, a count enable and a repeat request. Each address taken through the strobe is also written into a repeat base register. A burst can therefore be restarted at its first word without driving the address again. The block has no inputs for chip select, byte select or read/write direction. The counter runs and reloads on every edge, whether or not the port is performing an access.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low and after it is released, until the first clock edge with an action, addr_o reads 0 and rpt_base_o reads 0.
- R2: On a rising edge where rpt_ni is high and ads_ni is low, addr_o takes ext_addr_i after that edge, whatever cnt_en_ni is.
- R3: On a rising edge where rpt_ni, ads_ni and cnt_en_ni are all high, addr_o keeps its value and ext_addr_i has no effect.
- R4: On a rising edge where rpt_ni and ads_ni are high and cnt_en_ni is low, addr_o becomes its previous value plus one.
- R5: Counting from the all-ones address (2^ADDR_W - 1) yields address 0.
- R6: On a rising edge where rpt_ni is low, addr_o becomes the value rpt_base_o showed before that edge, whatever ads_ni, cnt_en_ni and ext_addr_i are. Repeat has top priority, then the strobe, then the count enable, then hold.
- R7: Every rising edge with ads_ni low stores ext_addr_i as the new repeat base, also when rpt_ni is low in the same cycle. rpt_base_o shows the stored value from the next cycle on.
- R8: If no strobe load has happened since reset, rpt_base_o reads 0 and a repeat request sends addr_o to 0.
- R9: The controls act on every edge. No other condition gates them, and the address width is set by ADDR_W (17 by default, 16 also supported).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_addr_i | input | ADDR_W | Address supplied from outside |
| ads_ni | input | 1 | Address strobe, active low |
| cnt_en_ni | input | 1 | Count enable, active low |
| rpt_ni | input | 1 | Repeat request, active low |
| addr_o | output | ADDR_W | Registered internal address to the array |
| rpt_base_o | output | ADDR_W | Stored repeat base (0 until first load) |

## Verification
The bench drives repeat together with the strobe in the same cycle. A design that let the strobe win, or that skipped the base update, would show the new external address instead of the old base, or would repeat to a stale base later. The bench also issues a repeat before any load. A design without the unloaded flag would return an undefined address instead of zero. The bench loads the all-ones address and counts from it, which catches an increment that saturates or carries out of the width. Long random runs with hold cycles and a changing ext_addr_i show whether a design leaks the external address into the hold path.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_RPT  = 2'd3
  } addr_op_e;
endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
  import burst_addr_pkg::*;
(
  input  logic     ads_ni,
  input  logic     cnt_en_ni,
  input  logic     rpt_ni,
  output addr_op_e op_o,
  output logic     base_load_o
);
  // repeat > strobe > count > hold
  always_comb begin
    if (!rpt_ni)         op_o = OP_RPT;
    else if (!ads_ni)    op_o = OP_LOAD;
    else if (!cnt_en_ni) op_o = OP_INC;
    else                 op_o = OP_HOLD;
  end

  // base capture follows the strobe alone, even under repeat
  assign base_load_o = !ads_ni;
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  addr_op_e          op_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] ext_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (op_i)
      OP_RPT:  nxt_o = base_i;
      OP_LOAD: nxt_o = ext_i;
      OP_INC:  nxt_o = cur_i + ONE; // natural wrap
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_repeat.sv
module burst_addr_repeat #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q;
  logic              loaded_q;

  // data flops carry no reset; loaded_q masks them
  always_ff @(posedge clk_i) begin
    if (load_i) base_q <= addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     loaded_q <= 1'b0;
    else if (load_i) loaded_q <= 1'b1;
  end

  assign base_o = loaded_q ? base_q : '0;

  // R7
  base_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_o == $past(addr_i));

  // R8
  base_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> base_o == $past(base_o));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              ads_ni,
  input  logic              cnt_en_ni,
  input  logic              rpt_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] rpt_base_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  addr_op_e          op;
  logic              base_load;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] addr_q;

  burst_addr_decode u_dec (
    .ads_ni      (ads_ni),
    .cnt_en_ni   (cnt_en_ni),
    .rpt_ni      (rpt_ni),
    .op_o        (op),
    .base_load_o (base_load)
  );

  burst_addr_repeat #(.ADDR_W(ADDR_W)) u_rpt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (base_load),
    .addr_i (ext_addr_i),
    .base_o (rpt_base_o)
  );

  burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .op_i   (op),
    .cur_i  (addr_q),
    .ext_i  (ext_addr_i),
    .base_i (rpt_base_o),
    .nxt_o  (nxt_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= nxt_addr;
  end

  assign addr_o = addr_q;

  // R2
  ext_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni && !ads_ni) |=> addr_o == $past(ext_addr_i));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni && ads_ni && cnt_en_ni) |=> $stable(addr_o));

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni && ads_ni && !cnt_en_ni) |=> addr_o == $past(addr_o) + ONE);

  // R6
  repeat_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rpt_ni |=> addr_o == $past(rpt_base_o));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 17;
  localparam logic [AW-1:0] MAXA = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext = '0;
  logic          ads_n = 1'b1, cnt_n = 1'b1, rpt_n = 1'b1;
  logic [AW-1:0] addr, base;

  int n_cmp = 0, n_bad = 0;
  logic [AW-1:0] m_addr = '0, m_base = '0;
  bit            m_loaded = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_addr_i(ext), .ads_ni(ads_n),
    .cnt_en_ni(cnt_n), .rpt_ni(rpt_n), .addr_o(addr), .rpt_base_o(base)
  );

  function automatic logic [AW-1:0] nxt_addr(logic a, logic c, logic r, logic [AW-1:0] e);
    if (!r)      return m_loaded ? m_base : '0;
    else if (!a) return e;
    else if (!c) return m_addr + AW'(1);
    else         return m_addr;
  endfunction

  function automatic string tag_of(logic a, logic c, logic r, logic [AW-1:0] cur);
    if (!r)      return m_loaded ? "R6" : "R8";
    else if (!a) return "R2";
    else if (!c) return (cur == MAXA) ? "R5" : "R4";
    else         return "R3";
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called just after a negedge
  task automatic step(logic a, logic c, logic r, logic [AW-1:0] e);
    string t;
    t = tag_of(a, c, r, m_addr);
    ads_n = a; cnt_n = c; rpt_n = r; ext = e;
    m_addr = nxt_addr(a, c, r, e);
    if (!a) begin m_base = e; m_loaded = 1'b1; end
    @(negedge clk);
    chk(t, addr, m_addr);
    chk(!a ? "R7" : "R9", base, m_loaded ? m_base : '0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1
    chk("R1", addr, '0);
    chk("R1", base, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", addr, '0);
    chk("R1", base, '0);

    // R8: repeat before any load, with a stray address present
    step(1, 0, 1, 17'h0_0055);
    step(1, 1, 0, 17'h1_2345);
    // R3: hold ignores ext
    step(1, 1, 1, 17'h1_FFFF);
    // R2 then R4 and R5 wrap
    step(0, 0, 1, MAXA - AW'(1));
    step(1, 0, 1, 17'h0_0000);
    step(1, 0, 1, 17'h0_0000);
    step(1, 0, 1, 17'h0_0000);
    // R7 and R6: strobe and repeat together, repeat wins, base updated
    step(0, 1, 0, 17'h0_0ABC);
    step(1, 1, 0, 17'h0_0000);
    step(0, 0, 0, 17'h1_0001);
    step(1, 0, 1, 17'h0_0000);
    step(1, 1, 0, 17'h0_0000);

    // random mix, R9: controls acting on every edge
    for (int i = 0; i < 3000; i++) begin
      int unsigned p;
      logic a, c, r;
      logic [AW-1:0] e;
      p = $urandom_range(0, 99);
      a = (p % 5) != 0;
      c = $urandom_range(0, 99) < 45;
      r = $urandom_range(0, 99) >= 10;
      e = (p < 5) ? MAXA : AW'($urandom());
      step(a, c, r, e);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule